// File: doc/BRIEF.md
# Parallel DAC Interface Controller

This block connects a streaming sample source to a clocked 10-bit parallel-input converter. It divides the system clock down to produce the converter clock, and it drives the chip select, the data bus and the two power-control pins. It accepts samples through a valid/ready handshake and takes power-mode requests through a small command port.

The block moves the converter between three power modes: active, standby and shutdown. After an active request from standby or shutdown, it keeps the converter powered but refuses samples until a settling countdown ends. The length of that countdown comes from the system clock frequency and a wake time in nanoseconds. The data bus and the chip select only change when the converter clock falls, so the data is stable for a full half period before each rising edge.

The block also models the converter's two internal registers. Its output code therefore always shows the value the converter is presenting, which lags the bus by one converter clock.

Top module: `dac_seq_ctrl`

## Requirements
- R1: While reset is held and just after it is released, the block shows shutdown: `dac_pd_o`=1, `dac_en_o`=0, `dac_cs_no`=1 and `s_ready_o`=0. `dac_data_o` and `out_code_o` both equal `IDLE_CODE`, which defaults to 512 (mid-scale).
- R2: `dac_clk_o` is a square wave with a period of 2*`HALF_DIV` system cycles, high for `HALF_DIV` cycles and low for `HALF_DIV` cycles. The default of 2 gives 32 ns at 125 MHz.
- R3: `dac_data_o` and `dac_cs_no` change only on the system edge at which `dac_clk_o` falls. They never change while the converter clock is high.
- R4: The power pins encode the mode as follows: active gives pd=0, en=1; standby gives pd=0, en=0; shutdown gives pd=1, en=0. Command codes on `cmd_mode_i` are 2'b00 active, 2'b01 standby, and 2'b10 or 2'b11 shutdown. A command takes effect on the cycle after the one in which `cmd_valid_i` is sampled high.
- R5: An active command given in standby or shutdown starts a wake phase. During this phase the pins read pd=0, en=1 and `s_ready_o` stays low for `WAKE_CYCLES` = ceil(`SYS_CLK_HZ`*`WAKE_NS`/1e9) cycles. The first ready comes between `WAKE_CYCLES`+1 and `WAKE_CYCLES`+2*`HALF_DIV` cycles after the command cycle.
- R6: A standby or shutdown command given during the wake phase ends it at once, and no ready follows. An active command given during the wake phase, or while already active, is ignored and does not restart the countdown.
- R7: `s_ready_o` is high only in active mode, for one system cycle per converter clock period: the last cycle before `dac_clk_o` falls. A sample accepted in that cycle appears on `dac_data_o` at that falling edge.
- R8: At every falling edge outside active mode, `dac_data_o` is loaded with `IDLE_CODE`. In active mode a falling edge with no accepted sample leaves the bus unchanged.
- R9: `dac_cs_no` is low during the wake phase and in active mode, and high in standby and shutdown. It is updated at converter clock falling edges.
- R10: At each rising edge of `dac_clk_o` with `dac_cs_no` low, `out_code_o` takes the value held in the modelled input register, and that register takes `dac_data_o`. When `dac_cs_no` is high, both registers are frozen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_valid_i | input | 1 | Mode command strobe |
| cmd_mode_i | input | 2 | Requested mode: 00 active, 01 standby, 1x shutdown |
| s_valid_i | input | 1 | Sample valid |
| s_data_i | input | DATA_W | Sample code |
| s_ready_o | output | 1 | Sample accepted this cycle when valid is also high |
| dac_clk_o | output | 1 | Converter clock |
| dac_cs_no | output | 1 | Converter chip select, active low |
| dac_data_o | output | DATA_W | Converter data bus, bit 0 is the LSB |
| dac_pd_o | output | 1 | Power-down select pin |
| dac_en_o | output | 1 | Converter enable pin |
| out_code_o | output | DATA_W | Code currently presented by the converter |

## Verification
A wrong wake count shows up as a first ready that comes too early or too late, measured in cycles from the command. An abort that fails to take effect shows up as a ready appearing in a window where none is allowed. A mode register in the wrong state shows at once on the power pins, and it shows at the next converter falling edge on the chip select and the bus. A slip in the pipeline model shows on `out_code_o` at the first rising converter edge: a port-level model of the two converter registers no longer agrees with it. A bus that is updated in the wrong system cycle shows as a change of `dac_data_o` while the converter clock is high.

// File: rtl/dac_seq_pkg.sv
package dac_seq_pkg;
  typedef enum logic [1:0] {
    MODE_SHDN = 2'd0,
    MODE_STBY = 2'd1,
    MODE_WAKE = 2'd2,
    MODE_ACT  = 2'd3
  } pwr_mode_e;

  localparam logic [1:0] CMD_ACT  = 2'b00;
  localparam logic [1:0] CMD_STBY = 2'b01;
endpackage

// File: rtl/dac_clk_gen.sv
module dac_clk_gen #(
  parameter int HALF_DIV = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic dac_clk_o,
  output logic rise_o,
  output logic fall_o
);
  localparam int CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;

  logic [CW-1:0] cnt_q;
  logic          clk_q;
  logic          tick;

  assign tick = (cnt_q == CW'(HALF_DIV - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      clk_q <= 1'b0;
    end else if (tick) begin
      cnt_q <= '0;
      clk_q <= ~clk_q;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign dac_clk_o = clk_q;
  assign rise_o    = tick & ~clk_q;
  assign fall_o    = tick & clk_q;

  AST_CLK_EDGE_ON_TICK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clk_q != $past(clk_q)) |-> $past(tick)); // R2
endmodule

// File: rtl/dac_pwr_fsm.sv
module dac_pwr_fsm
  import dac_seq_pkg::*;
#(
  parameter int WAKE_CYCLES = 16
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       cmd_valid_i,
  input  logic [1:0] cmd_mode_i,
  output pwr_mode_e  mode_o
);
  localparam int WW = $clog2(WAKE_CYCLES + 1);

  pwr_mode_e mode_q, mode_d;
  logic [WW-1:0] cnt_q, cnt_d;
  pwr_mode_e low_mode;
  logic      go_low, go_act;

  assign low_mode = (cmd_mode_i == CMD_STBY) ? MODE_STBY : MODE_SHDN;
  assign go_low   = cmd_valid_i && (cmd_mode_i != CMD_ACT);
  assign go_act   = cmd_valid_i && (cmd_mode_i == CMD_ACT);

  always_comb begin
    mode_d = mode_q;
    cnt_d  = cnt_q;
    if (go_low) begin
      mode_d = low_mode;
      cnt_d  = '0;
    end else begin
      unique case (mode_q)
        MODE_SHDN, MODE_STBY: if (go_act) begin
          mode_d = MODE_WAKE;
          cnt_d  = WW'(WAKE_CYCLES - 1);
        end
        MODE_WAKE: begin
          if (cnt_q == '0) mode_d = MODE_ACT;
          else             cnt_d  = cnt_q - 1'b1;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= MODE_SHDN;
      cnt_q  <= '0;
    end else begin
      mode_q <= mode_d;
      cnt_q  <= cnt_d;
    end
  end

  assign mode_o = mode_q;

  AST_WAKE_BEFORE_ACTIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q == MODE_ACT && $past(mode_q) != MODE_ACT) |-> $past(mode_q) == MODE_WAKE); // R5
  AST_WAKE_CNT_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q == MODE_WAKE) |-> (cnt_q < WW'(WAKE_CYCLES))); // R5
  AST_LOW_CMD_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid_i && cmd_mode_i != CMD_ACT) |=> (mode_q == MODE_STBY || mode_q == MODE_SHDN)); // R6
endmodule

// File: rtl/dac_bus_pipe.sv
module dac_bus_pipe #(
  parameter int              DATA_W    = 10,
  parameter logic [DATA_W-1:0] IDLE_CODE = DATA_W'(1) << (DATA_W - 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              dac_clk_i,
  input  logic              rise_i,
  input  logic              fall_i,
  input  logic              active_i,
  input  logic              powered_i,
  input  logic              s_valid_i,
  input  logic [DATA_W-1:0] s_data_i,
  output logic              s_ready_o,
  output logic [DATA_W-1:0] bus_o,
  output logic              cs_n_o,
  output logic [DATA_W-1:0] out_code_o
);
  logic [DATA_W-1:0] bus_q, in_q, out_q;
  logic              cs_n_q;

  assign s_ready_o = active_i & fall_i;

  // bus and select move only on the falling converter edge
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bus_q  <= IDLE_CODE;
      cs_n_q <= 1'b1;
    end else if (fall_i) begin
      cs_n_q <= ~powered_i;
      if (!active_i)      bus_q <= IDLE_CODE;
      else if (s_valid_i) bus_q <= s_data_i;
    end
  end

  // converter input and output registers
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      in_q  <= IDLE_CODE;
      out_q <= IDLE_CODE;
    end else if (rise_i && !cs_n_q) begin
      in_q  <= bus_q;
      out_q <= in_q;
    end
  end

  assign bus_o      = bus_q;
  assign cs_n_o     = cs_n_q;
  assign out_code_o = out_q;

  AST_BUS_HOLD_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dac_clk_i && $past(dac_clk_i)) |-> ($stable(bus_q) && $stable(cs_n_q))); // R3
  AST_OUT_FROZEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rise_i && cs_n_q) |=> $stable(out_q)); // R10
  AST_READY_CLK_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    s_ready_o |-> dac_clk_i); // R7
endmodule

// File: rtl/dac_seq_ctrl.sv
module dac_seq_ctrl
  import dac_seq_pkg::*;
#(
  parameter int                DATA_W     = 10,
  parameter int                SYS_CLK_HZ = 125_000_000,
  parameter int                WAKE_NS    = 50_000,
  parameter int                HALF_DIV   = 2,
  parameter logic [DATA_W-1:0] IDLE_CODE  = DATA_W'(1) << (DATA_W - 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cmd_valid_i,
  input  logic [1:0]        cmd_mode_i,
  input  logic              s_valid_i,
  input  logic [DATA_W-1:0] s_data_i,
  output logic              s_ready_o,
  output logic              dac_clk_o,
  output logic              dac_cs_no,
  output logic [DATA_W-1:0] dac_data_o,
  output logic              dac_pd_o,
  output logic              dac_en_o,
  output logic [DATA_W-1:0] out_code_o
);
  localparam longint WAKE_L = (longint'(SYS_CLK_HZ) * longint'(WAKE_NS)
                               + longint'(999_999_999)) / longint'(1_000_000_000);
  localparam int WAKE_CYCLES = (WAKE_L < 1) ? 1 : int'(WAKE_L);

  pwr_mode_e mode;
  logic      rise, fall;

  dac_clk_gen #(.HALF_DIV(HALF_DIV)) i_clk_gen (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .dac_clk_o (dac_clk_o),
    .rise_o    (rise),
    .fall_o    (fall)
  );

  dac_pwr_fsm #(.WAKE_CYCLES(WAKE_CYCLES)) i_pwr_fsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .cmd_valid_i (cmd_valid_i),
    .cmd_mode_i  (cmd_mode_i),
    .mode_o      (mode)
  );

  dac_bus_pipe #(.DATA_W(DATA_W), .IDLE_CODE(IDLE_CODE)) i_bus_pipe (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .dac_clk_i  (dac_clk_o),
    .rise_i     (rise),
    .fall_i     (fall),
    .active_i   (mode == MODE_ACT),
    .powered_i  (mode == MODE_ACT || mode == MODE_WAKE),
    .s_valid_i  (s_valid_i),
    .s_data_i   (s_data_i),
    .s_ready_o  (s_ready_o),
    .bus_o      (dac_data_o),
    .cs_n_o     (dac_cs_no),
    .out_code_o (out_code_o)
  );

  assign dac_pd_o = (mode == MODE_SHDN);
  assign dac_en_o = (mode == MODE_WAKE) || (mode == MODE_ACT);

  AST_PD_EN_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dac_pd_o |-> !dac_en_o); // R4
  AST_READY_POWERED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    s_ready_o |-> (!dac_pd_o && dac_en_o && !dac_cs_no)); // R7
endmodule

// File: tb/test_dac_seq_ctrl.sv
module test_dac_seq_ctrl;
  localparam int DW   = 10;
  localparam int HZ   = 125_000_000;
  localparam int WNS  = 1000;
  localparam int HALF = 2;
  localparam logic [DW-1:0] IDLE = 10'd512;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmd_valid = 1'b0;
  logic [1:0] cmd_mode = 2'b00;
  logic s_valid = 1'b0;
  logic [DW-1:0] s_data = '0;
  logic s_ready, dac_clk, cs_n, pd, en;
  logic [DW-1:0] dac_data, out_code;

  always #4 clk = ~clk;

  dac_seq_ctrl #(.DATA_W(DW), .SYS_CLK_HZ(HZ), .WAKE_NS(WNS), .HALF_DIV(HALF), .IDLE_CODE(IDLE))
  i_dac_seq_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .cmd_valid_i(cmd_valid), .cmd_mode_i(cmd_mode),
    .s_valid_i(s_valid), .s_data_i(s_data), .s_ready_o(s_ready), .dac_clk_o(dac_clk),
    .dac_cs_no(cs_n), .dac_data_o(dac_data), .dac_pd_o(pd), .dac_en_o(en), .out_code_o(out_code)
  );

  int tests = 0;
  int fails = 0;

  function automatic int exp_wake(longint hz, longint ns);
    return int'((hz * ns + 999_999_999) / 1_000_000_000);
  endfunction
  localparam int W = 125;

  function automatic logic [1:0] exp_pins(logic [1:0] cmd);
    if (cmd == 2'b00) return 2'b01;
    if (cmd == 2'b01) return 2'b00;
    return 2'b10;
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  // port-level monitor and converter model
  bit mon_en = 0;
  logic prev_clk, prev_cs;
  logic [DW-1:0] prev_data, m_in, m_out, pend_data;
  bit pend = 0, seen_tog = 0;
  int run = 0, clk_err = 0, bus_err = 0, pipe_err = 0, pipe_n = 0;
  int acc_err = 0, acc_n = 0, rdy_err = 0;

  always @(negedge clk) if (mon_en) begin
    if (dac_clk != prev_clk) begin
      if (seen_tog && run != HALF) clk_err++;
      seen_tog = 1; run = 1;
    end else run++;
    if ((dac_data != prev_data || cs_n != prev_cs) && !(prev_clk && !dac_clk)) bus_err++;
    if (dac_clk && !prev_clk && !cs_n) begin
      m_out = m_in; m_in = dac_data; pipe_n++;
    end
    if (out_code != m_out) pipe_err++;
    if (pend) begin
      if (dac_data != pend_data) acc_err++;
      acc_n++; pend = 0;
    end
    if (s_valid && s_ready) begin pend = 1; pend_data = s_data; end
    if (s_ready && (pd || !en || !dac_clk)) rdy_err++;
    prev_clk = dac_clk; prev_cs = cs_n; prev_data = dac_data;
  end

  task automatic tick(int n);
    repeat (n) begin @(posedge clk); #1; end
  endtask

  task automatic send_cmd(logic [1:0] m);
    cmd_valid = 1; cmd_mode = m; tick(1); cmd_valid = 0;
  endtask

  // active command, optional command at count 40, count cycles to first ready
  task automatic wake_seq(int mid, int lim, output int n, output int bad);
    n = 0; bad = 0;
    cmd_valid = 1; cmd_mode = 2'b00;
    @(posedge clk); #1 cmd_valid = 0;
    forever begin
      @(negedge clk); n++;
      if (mid >= 0 && n == 40) begin cmd_valid = 1; cmd_mode = 2'(mid); end
      if (n == 41) cmd_valid = 0;
      if (mid < 0 || mid == 0) begin
        if (pd || !en) bad++;
      end
      if (s_ready || n >= lim) break;
    end
    @(posedge clk); #1;
  endtask

  task automatic send_one(logic [DW-1:0] d);
    s_valid = 1; s_data = d;
    do @(negedge clk); while (!s_ready);
    @(posedge clk); #1 s_valid = 0;
  endtask

  task automatic stream(int cycles);
    repeat (cycles) begin
      s_valid = ($urandom % 4) != 0;
      s_data = DW'($urandom);
      tick(1);
    end
    s_valid = 0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++; tests++;
    $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
    summary();
  end

  initial begin
    int n, bad;
    logic [DW-1:0] hold;
    void'($urandom(32'h5eed_1234));
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    prev_clk = dac_clk; prev_cs = cs_n; prev_data = dac_data;
    m_in = IDLE; m_out = IDLE; mon_en = 1;
    @(negedge clk);
    chk(pd == 1 && en == 0, "R1 pins", {pd, en}, 2);
    chk(cs_n == 1 && s_ready == 0, "R1 cs/ready", {cs_n, s_ready}, 2);
    chk(dac_data == IDLE && out_code == IDLE, "R1 codes", out_code, IDLE);
    chk(exp_wake(HZ, WNS) == W, "R5 wake formula", exp_wake(HZ, WNS), W);

    // shutdown -> active wake
    tick(1);
    wake_seq(-1, W + 40, n, bad);
    chk(n >= W + 1 && n <= W + 2 * HALF, "R5 wake length", n, W + 1);
    chk(bad == 0, "R5 pins during wake", bad, 0);
    tick(12);
    chk(dac_data == IDLE && out_code == IDLE, "R8 idle after wake", out_code, IDLE);
    chk(cs_n == 0, "R9 cs low active", cs_n, 0);

    // lag of one converter clock
    send_one(10'h3FF);
    tick(4 * HALF * 2);
    chk(out_code == 10'h3FF && dac_data == 10'h3FF, "R10 full scale / R8 hold", out_code, 10'h3FF);
    send_one(10'h000);
    do @(negedge clk); while (!dac_clk);
    chk(out_code == 10'h3FF, "R10 lag one clock", out_code, 10'h3FF);
    do @(negedge clk); while (dac_clk);
    do @(negedge clk); while (!dac_clk);
    chk(out_code == 10'h000, "R10 zero scale", out_code, 0);
    tick(1);

    stream(2000);
    tick(8);

    // standby
    send_cmd(2'b01);
    @(negedge clk);
    chk({pd, en} == exp_pins(2'b01), "R4 standby pins", {pd, en}, exp_pins(2'b01));
    chk(s_ready == 0, "R7 no ready standby", s_ready, 0);
    tick(2 * HALF + 1);
    hold = out_code;
    chk(cs_n == 1 && dac_data == IDLE, "R9/R8 standby cs and bus", dac_data, IDLE);
    s_valid = 1; s_data = 10'h155; tick(30); s_valid = 0;
    @(negedge clk);
    chk(out_code == hold, "R10 frozen in standby", out_code, hold);
    tick(1);

    // standby -> active, then random traffic
    wake_seq(-1, W + 40, n, bad);
    chk(n >= W + 1 && n <= W + 2 * HALF, "R5 wake from standby", n, W + 1);
    stream(1500);
    tick(8);

    // shutdown via code 2'b11
    send_cmd(2'b11);
    @(negedge clk);
    chk({pd, en} == 2'b10, "R4 shutdown 11 pins", {pd, en}, 2);
    tick(10);

    // abort wake with shutdown
    wake_seq(2, W + 20, n, bad);
    chk(n == W + 20, "R6 abort no ready", n, W + 20);
    @(negedge clk);
    chk({pd, en} == exp_pins(2'b10), "R6 abort pins", {pd, en}, exp_pins(2'b10));
    tick(1);

    // repeated active during wake does not restart
    wake_seq(0, W + 80, n, bad);
    chk(n >= W + 1 && n <= W + 2 * HALF, "R6 active ignored in wake", n, W + 1);
    stream(500);
    tick(8);

    chk(clk_err == 0 && seen_tog, "R2 clock shape", clk_err, 0);
    chk(bus_err == 0, "R3 bus changes only at fall", bus_err, 0);
    chk(pipe_err == 0 && pipe_n > 100, "R10 pipeline model", pipe_err, 0);
    chk(acc_err == 0 && acc_n > 100, "R7 accepted sample on bus", acc_err, 0);
    chk(rdy_err == 0, "R7 ready only active before fall", rdy_err, 0);
    summary();
  end
endmodule